// File: doc/BRIEF.md
# TDM-8 Audio Serial Transmitter

This block turns a set of eight parallel audio samples into one time-division-multiplexed serial frame for a multichannel DAC. A frame is 256 bit periods long and holds eight 32-bit slots. Each slot carries one 24-bit sample, most significant bit first and left-aligned in the slot, followed by eight low padding bits. The bit clock itself is produced elsewhere. The block receives a one-cycle enable that marks each falling bit-clock edge, so the serial data and the frame sync change there and the DAC can sample them on the rising edge.

Samples come in through a valid/ready load port into a one-deep staging register. At every frame boundary the staged set is copied into a shadow register, and that copy is shifted out during the new frame. The upstream side therefore has a whole frame to deliver the next set. An all-zero stream would make the DAC output drop silently to zero level. To avoid that, when nothing is staged at a boundary the block repeats the previous set and raises an underrun pulse. The frame sync is high for one bit period, and the data lags it by one bit period.

Top module: `tdm8_tx`

## Requirements
- R1: The frame sync output is high for exactly one bit period out of every 256 bit periods. A bit period runs from one enable pulse to the next.
- R2: The serial data is delayed by one bit period after the frame sync. The first bit of slot 0 appears in the bit period that follows the one in which the frame sync is high.
- R3: Channel c (0 to 7) is sent in slot c, most significant bit first. At bit-period position p after the frame sync (the frame sync period is p=0), positions p = 1+32c through 24+32c carry bits 23 down to 0 of channel c.
- R4: The eight trailing bits of every slot are driven low. This includes position 0, which carries the last pad bit of slot 7.
- R5: The serial data and the frame sync change only in the clock cycle after an enable pulse and hold their values in every other cycle.
- R6: The load-ready output is high when the staging register is empty. A set is captured when load-valid and load-ready are both high at a clock edge. Channel c is taken from load data bits [24c+23:24c]. A set captured during a frame is sent in the next frame.
- R7: After a set has been captured, load-ready stays low until the next frame boundary has moved that set into the shadow register.
- R8: If no set is staged at a frame boundary, the previous set is sent again. The underrun output is then high for exactly one clock cycle, the same cycle in which the frame sync goes high. At any other time the underrun output is low.
- R9: During and right after reset, the serial data, the frame sync and the underrun output are low and load-ready is high. The first enable pulse after reset starts a frame whose samples are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle pulse marking a falling bit-clock edge |
| smp_valid_i | input | 1 | Load-valid for a set of eight samples |
| smp_data_i | input | 192 | Eight 24-bit samples; channel c in bits [24c+23:24c] |
| smp_ready_o | output | 1 | Staging register free |
| tdm_sdata_o | output | 1 | Serial audio data |
| tdm_fsync_o | output | 1 | Frame sync, high for one bit period at slot 0 |
| underrun_o | output | 1 | One-cycle pulse when the previous set is repeated |

## Verification
The serial data and the frame sync are registered, so each takes its new value in the clock cycle after the edge where the enable was high. The underrun pulse appears in that same cycle, at a boundary only. Load-ready falls one cycle after a handshake, and a staged set starts to appear at position 1 of the next frame. The monitor advances its own model of the frame position on each enable it drove. It compares every output at the falling clock edge after that rising edge, and in the cycles without an enable it checks that the outputs have held. The driver only offers new sets in the middle of a frame, so every handshake has an unambiguous target frame in the scoreboard queue.

// File: rtl/tdm8_pkg.sv
package tdm8_pkg;
   // Power-of-two test used by the elaboration checks.
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   // Defaults shared by the modules of this block.
   localparam int unsigned DEF_NCH    = 8;
   localparam int unsigned DEF_SMP_W  = 24;
   localparam int unsigned DEF_SLOT_W = 32;
   localparam int unsigned DEF_DELAY  = 1;
endpackage

// File: rtl/tdm8_frame_ctr.sv
module tdm8_frame_ctr #(
   parameter int unsigned FRAME_BITS = 256,
   localparam int unsigned POS_W = $clog2(FRAME_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   output logic [POS_W-1:0] npos_o,
   output logic             wrap_o,
   output logic             fsync_o
);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

   logic [POS_W-1:0] pos_q;

   if (!tdm8_pkg::is_pow2(FRAME_BITS) || FRAME_BITS < 4) begin : g_bad_frame
      $error("tdm8_frame_ctr: FRAME_BITS must be a power of two >= 4");
   end

   assign npos_o = pos_q + POS_W'(1);
   assign wrap_o = bit_en && (npos_o == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= LAST_POS;
         fsync_o <= 1'b0;
      end else if (bit_en) begin
         pos_q   <= npos_o;
         fsync_o <= (npos_o == '0);
      end
   end

   // R1
   fsync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fsync_o && bit_en) |=> !fsync_o);

   // R5
   fsync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(fsync_o));
endmodule

// File: rtl/tdm8_sample_stage.sv
module tdm8_sample_stage #(
   parameter int unsigned NCH   = 8,
   parameter int unsigned SMP_W = 24,
   localparam int unsigned SET_W = NCH * SMP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             smp_valid_i,
   input  logic [SET_W-1:0] smp_data_i,
   output logic             smp_ready_o,
   output logic [SET_W-1:0] shadow_o,
   output logic             underrun_o
);
   logic [SET_W-1:0] hold_q;
   logic             hold_full_q;
   logic             accept;

   assign smp_ready_o = !hold_full_q;
   assign accept      = smp_valid_i && smp_ready_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= '0;
         hold_full_q <= 1'b0;
         shadow_o    <= '0;
         underrun_o  <= 1'b0;
      end else begin
         underrun_o <= frame_start && !hold_full_q;
         if (frame_start && hold_full_q) begin
            shadow_o <= hold_q;
         end
         if (accept) begin
            hold_q      <= smp_data_i;
            hold_full_q <= 1'b1;
         end else if (frame_start) begin
            hold_full_q <= 1'b0;
         end
      end
   end

   // R7
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid_i && smp_ready_o) |=> !smp_ready_o);

   // R8
   underrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_o |=> !underrun_o);
endmodule

// File: rtl/tdm8_bit_sel.sv
module tdm8_bit_sel #(
   parameter int unsigned NCH       = 8,
   parameter int unsigned SMP_W     = 24,
   parameter int unsigned SLOT_W    = 32,
   parameter int unsigned DELAY     = 1,
   parameter bit          MSB_FIRST = 1'b1,
   localparam int unsigned SET_W  = NCH * SMP_W,
   localparam int unsigned POS_W  = $clog2(NCH * SLOT_W),
   localparam int unsigned SB_W   = $clog2(SLOT_W),
   localparam int unsigned SL_W   = $clog2(NCH),
   localparam int unsigned IDX_W  = $clog2(SMP_W)
) (
   input  logic [POS_W-1:0] npos_i,
   input  logic [SET_W-1:0] shadow_i,
   output logic             bit_o
);
   localparam logic [SB_W:0]    SMP_LIM = (SB_W + 1)'(SMP_W);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(SMP_W - 1);

   logic [POS_W-1:0] fbit;
   logic [SB_W-1:0]  in_slot;
   logic [SL_W-1:0]  slot;
   logic             live;
   logic [IDX_W-1:0] idx;
   logic [NCH-1:0]   slot_bits;

   // Frame bit carried at this position, after the data delay.
   assign fbit    = npos_i - POS_W'(DELAY);
   assign in_slot = fbit[SB_W-1:0];
   assign slot    = fbit[POS_W-1:SB_W];
   assign live    = ({1'b0, in_slot} < SMP_LIM);

   if (MSB_FIRST) begin : g_msb
      assign idx = TOP_IDX - in_slot[IDX_W-1:0];
   end else begin : g_lsb
      assign idx = in_slot[IDX_W-1:0];
   end

   for (genvar s = 0; s < NCH; s++) begin : g_slot
      logic [SMP_W-1:0] chan;
      assign chan         = shadow_i[s*SMP_W +: SMP_W];
      assign slot_bits[s] = live && chan[idx];
   end

   assign bit_o = slot_bits[slot];
endmodule

// File: rtl/tdm8_tx.sv
module tdm8_tx #(
   parameter int unsigned NCH       = tdm8_pkg::DEF_NCH,
   parameter int unsigned SMP_W     = tdm8_pkg::DEF_SMP_W,
   parameter int unsigned SLOT_W    = tdm8_pkg::DEF_SLOT_W,
   parameter int unsigned DELAY     = tdm8_pkg::DEF_DELAY,
   parameter bit          MSB_FIRST = 1'b1,
   localparam int unsigned SET_W      = NCH * SMP_W,
   localparam int unsigned FRAME_BITS = NCH * SLOT_W,
   localparam int unsigned POS_W      = $clog2(FRAME_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             smp_valid_i,
   input  logic [SET_W-1:0] smp_data_i,
   output logic             smp_ready_o,
   output logic             tdm_sdata_o,
   output logic             tdm_fsync_o,
   output logic             underrun_o
);
   localparam int unsigned PAD_BITS = SLOT_W - SMP_W;

   if (NCH < 2 || !tdm8_pkg::is_pow2(NCH)) begin : g_bad_nch
      $error("tdm8_tx: NCH must be a power of two >= 2");
   end
   if (!tdm8_pkg::is_pow2(SLOT_W) || SMP_W < 2 || SMP_W > SLOT_W) begin : g_bad_slot
      $error("tdm8_tx: SLOT_W must be a power of two holding SMP_W");
   end
   if (DELAY > PAD_BITS) begin : g_bad_delay
      $error("tdm8_tx: DELAY must not exceed the slot padding");
   end

   logic [POS_W-1:0] npos;
   logic             wrap;
   logic [SET_W-1:0] shadow;
   logic             next_bit;

   tdm8_frame_ctr #(.FRAME_BITS(FRAME_BITS)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_en  (bit_en),
      .npos_o  (npos),
      .wrap_o  (wrap),
      .fsync_o (tdm_fsync_o)
   );

   tdm8_sample_stage #(.NCH(NCH), .SMP_W(SMP_W)) u_stage (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (wrap),
      .smp_valid_i (smp_valid_i),
      .smp_data_i  (smp_data_i),
      .smp_ready_o (smp_ready_o),
      .shadow_o    (shadow),
      .underrun_o  (underrun_o)
   );

   tdm8_bit_sel #(
      .NCH(NCH), .SMP_W(SMP_W), .SLOT_W(SLOT_W),
      .DELAY(DELAY), .MSB_FIRST(MSB_FIRST)
   ) u_sel (
      .npos_i   (npos),
      .shadow_i (shadow),
      .bit_o    (next_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdm_sdata_o <= 1'b0;
      end else if (bit_en) begin
         tdm_sdata_o <= next_bit;
      end
   end

   // R8
   underrun_at_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_o |-> tdm_fsync_o);

   // R5
   sdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tdm_sdata_o));

   if (DELAY > 0) begin : g_pad_sync
      // R4
      sync_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tdm_fsync_o |-> !tdm_sdata_o);
   end
endmodule

// File: tb/tdm8_tx_tb.sv
module tdm8_tx_tb_top;
   localparam int CLK_P = 10;
   localparam int NCH = 8;
   localparam int SMP_W = 24;
   localparam int SLOT_W = 32;
   localparam int FBITS = NCH * SLOT_W;
   localparam int SET_W = NCH * SMP_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0;
   logic smp_valid = 1'b0;
   logic [SET_W-1:0] smp_data = '0;
   logic smp_ready, sdata, fsync, underrun;

   int errors = 0;
   int checks = 0;
   bit running = 1'b0;
   bit done = 1'b0;
   int epos = FBITS - 1;
   int nfr = 0;
   logic [SET_W-1:0] exp_q[$];

   always #(CLK_P/2) clk = ~clk;

   tdm8_tx dut_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
      .smp_valid_i(smp_valid), .smp_data_i(smp_data),
      .smp_ready_o(smp_ready), .tdm_sdata_o(sdata),
      .tdm_fsync_o(fsync), .underrun_o(underrun)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   function automatic logic [SET_W-1:0] mk_set(input int seed);
      logic [SET_W-1:0] v;
      for (int c = 0; c < NCH; c++) begin
         v[c*SMP_W +: SMP_W] = 24'((seed * 32'h9E3779B1 + c * 32'h01234567) >> 4) ^ 24'(c << 20);
      end
      return v;
   endfunction

   // Bit-enable generator: one pulse every four clocks.
   initial begin
      int div = 0;
      forever begin
         @(negedge clk);
         bit_en = running && (div == 3);
         div = (div + 1) % 4;
      end
   end

   // Monitor and scoreboard.
   initial begin
      logic [SET_W-1:0] cur = '0;
      logic last_sd = 1'b0, last_fs = 1'b0;
      wait (running);
      forever begin
         logic e;
         @(posedge clk);
         e = bit_en;
         @(negedge clk);
         if (e) begin
            int fb, slot, b;
            logic ebit, eur;
            string tag;
            epos = (epos + 1) % FBITS;
            eur = 1'b0;
            if (epos == 0) begin
               nfr++;
               if (exp_q.size() > 0) cur = exp_q.pop_front();
               else eur = 1'b1;
            end
            fb = (epos + FBITS - 1) % FBITS;
            slot = fb / SLOT_W;
            b = fb % SLOT_W;
            ebit = (b < SMP_W) ? cur[slot*SMP_W + (SMP_W - 1 - b)] : 1'b0;
            tag = (b >= SMP_W) ? "R4" : ((epos == 1) ? "R2" : "R3");
            check("R1", "frame sync", 32'(fsync), 32'(epos == 0));
            check(tag, "serial bit", 32'(sdata), 32'(ebit));
            check("R8", "underrun at enable", 32'(underrun), 32'(eur));
            last_sd = sdata;
            last_fs = fsync;
         end else begin
            check("R5", "data hold", 32'(sdata), 32'(last_sd));
            check("R5", "sync hold", 32'(fsync), 32'(last_fs));
            check("R8", "underrun idle", 32'(underrun), 32'd0);
         end
      end
   end

   // Driver: offers one set in the middle of a frame and records it.
   task automatic load_set(input logic [SET_W-1:0] v);
      do @(negedge clk); while (!(epos >= 64 && epos <= 190 && smp_ready));
      smp_valid = 1'b1;
      smp_data = v;
      exp_q.push_back(v);
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   initial begin
      #(CLK_P * 200000);
      errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset values
      check("R9", "sdata in reset", 32'(sdata), 32'd0);
      check("R9", "fsync in reset", 32'(fsync), 32'd0);
      check("R9", "underrun in reset", 32'(underrun), 32'd0);
      check("R9", "ready in reset", 32'(smp_ready), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", "ready after reset", 32'(smp_ready), 32'd1);
      running = 1'b1;
      wait (nfr >= 1);
      // R6 set of all ones: pads must stay low
      load_set({SET_W{1'b1}});
      wait (nfr >= 2);
      load_set(mk_set(1));
      wait (nfr >= 3);
      // frame 3: nothing loaded, boundary 4 repeats (R8)
      wait (nfr >= 4);
      load_set(mk_set(2));
      // R7 staging full after handshake
      check("R7", "ready after capture", 32'(smp_ready), 32'd0);
      wait (nfr >= 5);
      repeat (2) @(negedge clk);
      check("R7", "ready after boundary", 32'(smp_ready), 32'd1);
      load_set(mk_set(3));
      wait (nfr >= 6);
      load_set(mk_set(4));
      wait (nfr >= 9);
      repeat (8) @(negedge clk);
      done = 1'b1;
      finish_run();
   end
endmodule